// File: doc/BRIEF.md
# Phase Vector Normalizer

This block turns two pairs of signed ratio readings into a unit-length sine/cosine pair in Q15 form. It forms the sine component from the difference of two magnitude ratios and the cosine component from the difference of two phase ratios. Each difference is scaled by a fixed delta factor. The block then estimates the length of the resulting vector without a square root. Finally it divides each component by that estimate, with the quotient scaled by 2^15.

A request is a one-cycle `start` pulse with the four inputs held on the same edge. The block answers with a one-cycle `done` pulse, and the normalized pair, the magnitude estimate and an error flag are valid on that pulse. When the estimate is zero the block flags an error and gives no normalized values. A downstream solver for the mismatch equations consumes the pair. That solver is not part of this block.

Top module: `phase_vec_norm`

## Requirements
- R1: The sine component is `S = wrap32(wrap32(mag_ref_i - mag_alt_i) * 256) / 32`. Here wrap32 keeps the low 32 bits as a signed value, and the division is exact.
- R2: The cosine component is `C = wrap32(wrap32(phs_alt_i - phs_ref_i) * 256) / 32`, with the same wrapping rule as R1.
- R3: On `done_o`, `mag_o` equals `hi - hi/32 + lo/8 + lo/4`. Here `hi` and `lo` are the larger and smaller of |C| and |S|, each division truncates, and the value is unsigned and 33 bits wide. When |C| equals |S|, |C| is taken as `lo`.
- R4: `mag_o` is zero only when both S and C are zero. Any nonzero component gives a nonzero estimate.
- R5: On a successful `done_o`, `sin_o` equals `sign(S) * (|S| * 32768 / mag_o)` and `cos_o` equals `sign(C) * (|C| * 32768 / mag_o)`. Each product is taken at full precision, and each quotient truncates toward zero.
- R6: If the estimate is zero, `err_o` is 1 on `done_o`, and `sin_o`, `cos_o` and `mag_o` are all 0.
- R7: `done_o` is high for exactly one cycle per accepted request. `err_o`, `sin_o`, `cos_o` and `mag_o` change only on the cycle `done_o` is high and hold until the next `done_o`. A successful request clears `err_o` to 0.
- R8: A `start` pulse that arrives while a request is in flight is ignored. The result still belongs to the first request.
- R9: After synchronous reset, `done_o`, `err_o`, `sin_o`, `cos_o` and `mag_o` are all 0.
- R10: `done_o` goes high after the clock edge that lies 50 edges after the edge that samples `start` when the estimate is nonzero. It goes high after the next edge (1 edge later) when the estimate is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; inputs are sampled on the same edge |
| mag_ref_i | input | 32 | Signed magnitude ratio, first reading |
| mag_alt_i | input | 32 | Signed magnitude ratio, second reading |
| phs_ref_i | input | 32 | Signed phase ratio, first reading |
| phs_alt_i | input | 32 | Signed phase ratio, second reading |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero-magnitude failure flag, valid with done_o |
| sin_o | output | 32 | Signed normalized sine, Q15 |
| cos_o | output | 32 | Signed normalized cosine, Q15 |
| mag_o | output | 33 | Unsigned magnitude estimate |

## Verification
The bench targets three groups of corner cases.

The first is sign handling. It uses negative components and a pair with equal absolute values. A divider that works on signed values directly, or that rounds toward minus infinity, would return a quotient one off or with the wrong sign.

The second is scaling. It uses a difference large enough that the multiply by 256 wraps. A design that widens before scaling would return a large positive sine where a negative one is due.

The third is the edges of the handshake. It covers the all-zero case, which must flag an error and return zeros on the short path. It also covers a second `start` raised mid-division, which a careless controller would accept and answer with the second request's values. Finally, it checks an error followed by a good request, where a sticky flag would leave `err_o` set.

// File: rtl/nv_pkg.sv
`timescale 1ns/1ps
package nv_pkg;

    localparam int DATA_W    = 32;
    localparam int ABS_W     = DATA_W + 1;
    localparam int FRAC_W    = 15;
    localparam int SCALE_SHL = 8;
    localparam int SCALE_SHR = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_DIV  = 2'd2
    } nv_state_e;

    typedef struct packed {
        logic             sin_neg;
        logic             cos_neg;
        logic [ABS_W-1:0] abs_sin;
        logic [ABS_W-1:0] abs_cos;
        logic [ABS_W-1:0] mag;
    } nv_front_t;

    // difference, wrapping multiply by 2^shl, exact divide by 2^shr
    function automatic logic signed [DATA_W-1:0] nv_scale(
        input logic signed [DATA_W-1:0] a,
        input logic signed [DATA_W-1:0] b,
        input int                       shl,
        input int                       shr
    );
        logic signed [DATA_W-1:0] diff;
        logic signed [DATA_W-1:0] prod;
        diff = a - b;
        prod = diff <<< shl;
        return prod >>> shr;
    endfunction

    function automatic logic [ABS_W-1:0] nv_abs(input logic signed [DATA_W-1:0] v);
        logic signed [ABS_W-1:0] w;
        w = {v[DATA_W-1], v};
        if (v[DATA_W-1])
            return $unsigned(-w);
        else
            return $unsigned(w);
    endfunction

    // shift-add length estimate; a tie puts the first operand in the low slot
    function automatic logic [ABS_W-1:0] nv_mag(
        input logic [ABS_W-1:0] first,
        input logic [ABS_W-1:0] second
    );
        logic [ABS_W-1:0] hi;
        logic [ABS_W-1:0] lo;
        if (first > second) begin
            hi = first;
            lo = second;
        end else begin
            hi = second;
            lo = first;
        end
        return hi - (hi >> 5) + (lo >> 3) + (lo >> 2);
    endfunction

endpackage

// File: rtl/nv_front.sv
`timescale 1ns/1ps
module nv_front
    import nv_pkg::*;
#(
    parameter int SHL = SCALE_SHL,
    parameter int SHR = SCALE_SHR
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic signed [DATA_W-1:0] mag_ref,
    input  logic signed [DATA_W-1:0] mag_alt,
    input  logic signed [DATA_W-1:0] phs_ref,
    input  logic signed [DATA_W-1:0] phs_alt,
    output nv_front_t                front_q
);

    logic signed [DATA_W-1:0] sin_c;
    logic signed [DATA_W-1:0] cos_c;
    nv_front_t                front_d;

    always_comb begin
        sin_c           = nv_scale(mag_ref, mag_alt, SHL, SHR);
        cos_c           = nv_scale(phs_alt, phs_ref, SHL, SHR);
        front_d.sin_neg = sin_c[DATA_W-1];
        front_d.cos_neg = cos_c[DATA_W-1];
        front_d.abs_sin = nv_abs(sin_c);
        front_d.abs_cos = nv_abs(cos_c);
        front_d.mag     = nv_mag(front_d.abs_cos, front_d.abs_sin);
    end

    always_ff @(posedge clk) begin
        if (rst)
            front_q <= '0;
        else if (load)
            front_q <= front_d;
    end

endmodule

// File: rtl/nv_divider.sv
`timescale 1ns/1ps
module nv_divider #(
    parameter int NUM_W = 48,
    parameter int DEN_W = 33,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [OUT_W-1:0] quo,
    output logic             fin
);

    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam int REM_W = DEN_W + 1;

    logic [REM_W-1:0] rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    logic [REM_W-1:0] shifted;
    logic [REM_W:0]   trial;

    always_comb begin
        shifted = {rem_q[REM_W-2:0], quo_q[NUM_W-1]};
        trial   = {1'b0, shifted} - {2'b00, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else if (go) begin
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
            cnt_q <= CNT_W'(NUM_W);
            run_q <= 1'b1;
            fin   <= 1'b0;
        end else if (run_q) begin
            if (!trial[REM_W])
                rem_q <= trial[REM_W-1:0];
            else
                rem_q <= shifted;
            quo_q <= {quo_q[NUM_W-2:0], ~trial[REM_W]};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                run_q <= 1'b0;
                fin   <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    assign quo = quo_q[OUT_W-1:0];

endmodule

// File: rtl/nv_ctrl.sv
`timescale 1ns/1ps
module nv_ctrl
    import nv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mag_zero,
    input  logic div_fin,
    output logic load,
    output logic div_go,
    output logic cap_ok,
    output logic cap_err,
    output logic busy,
    output logic done_q,
    output logic err_q
);

    nv_state_e st_q;

    always_comb begin
        load    = (st_q == ST_IDLE) && start;
        div_go  = (st_q == ST_PREP) && !mag_zero;
        cap_err = (st_q == ST_PREP) && mag_zero;
        cap_ok  = (st_q == ST_DIV) && div_fin;
        busy    = (st_q != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start)
                        st_q <= ST_PREP;
                end
                ST_PREP: begin
                    if (mag_zero) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        st_q <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b0;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/phase_vec_norm.sv
`timescale 1ns/1ps
module phase_vec_norm
    import nv_pkg::*;
#(
    parameter int SHL  = SCALE_SHL,
    parameter int SHR  = SCALE_SHR,
    parameter int FRAC = FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] mag_ref_i,
    input  logic signed [DATA_W-1:0] mag_alt_i,
    input  logic signed [DATA_W-1:0] phs_ref_i,
    input  logic signed [DATA_W-1:0] phs_alt_i,
    output logic                     done_o,
    output logic                     err_o,
    output logic signed [DATA_W-1:0] sin_o,
    output logic signed [DATA_W-1:0] cos_o,
    output logic [ABS_W-1:0]         mag_o
);

    localparam int NUM_W = ABS_W + FRAC;
    localparam int LANES = 2;

    nv_front_t   front;
    logic        load;
    logic        div_go;
    logic        cap_ok;
    logic        cap_err;
    logic        busy;
    logic        mag_zero;
    logic        div_fin;

    logic [ABS_W-1:0]  lane_abs [LANES];
    logic              lane_neg [LANES];
    logic [DATA_W-1:0] lane_quo [LANES];
    logic [DATA_W-1:0] lane_res [LANES];
    logic [LANES-1:0]  lane_fin;

    nv_front #(.SHL(SHL), .SHR(SHR)) u_front (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .mag_ref (mag_ref_i),
        .mag_alt (mag_alt_i),
        .phs_ref (phs_ref_i),
        .phs_alt (phs_alt_i),
        .front_q (front)
    );

    assign mag_zero = (front.mag == '0);

    // lane 0 carries the sine, lane 1 the cosine
    always_comb begin
        lane_abs[0] = front.abs_sin;
        lane_neg[0] = front.sin_neg;
        lane_abs[1] = front.abs_cos;
        lane_neg[1] = front.cos_neg;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nv_divider #(.NUM_W(NUM_W), .DEN_W(ABS_W), .OUT_W(DATA_W)) u_div (
            .clk (clk),
            .rst (rst),
            .go  (div_go),
            .num ({lane_abs[g], {FRAC{1'b0}}}),
            .den (front.mag),
            .quo (lane_quo[g]),
            .fin (lane_fin[g])
        );
        assign lane_res[g] = lane_neg[g] ? (~lane_quo[g] + 1'b1) : lane_quo[g];
    end

    assign div_fin = &lane_fin;

    nv_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mag_zero (mag_zero),
        .div_fin  (div_fin),
        .load     (load),
        .div_go   (div_go),
        .cap_ok   (cap_ok),
        .cap_err  (cap_err),
        .busy     (busy),
        .done_q   (done_o),
        .err_q    (err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_o <= '0;
            cos_o <= '0;
            mag_o <= '0;
        end else if (cap_err) begin
            sin_o <= '0;
            cos_o <= '0;
            mag_o <= '0;
        end else if (cap_ok) begin
            sin_o <= $signed(lane_res[0]);
            cos_o <= $signed(lane_res[1]);
            mag_o <= front.mag;
        end
    end

endmodule

// File: rtl/nv_checker.sv
`timescale 1ns/1ps
module nv_checker
    import nv_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     busy,
    input logic                     done_o,
    input logic                     err_o,
    input logic signed [DATA_W-1:0] sin_o,
    input logic signed [DATA_W-1:0] cos_o,
    input logic [ABS_W-1:0]         mag_o
);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_err_moves_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_o) |-> done_o);

    a_r7_data_moves_on_done: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sin_o) || !$stable(cos_o) || !$stable(mag_o)) |-> done_o);

    a_r6_zero_flags_err: assert property (@(posedge clk) disable iff (rst)
        (done_o && mag_o == '0) |-> (err_o && sin_o == '0 && cos_o == '0));

    a_r4_ok_has_mag: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (mag_o != '0));

    a_r8_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy));

endmodule

bind phase_vec_norm nv_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done_o (done_o),
    .err_o  (err_o),
    .sin_o  (sin_o),
    .cos_o  (cos_o),
    .mag_o  (mag_o)
);

// File: tb/sim_phase_vec_norm.sv
`timescale 1ns/1ps
module sim_phase_vec_norm;

    localparam int LAT_OK  = 32 + 1 + 15 + 2;
    localparam int LAT_ERR = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic signed [31:0] mag_ref_i = '0;
    logic signed [31:0] mag_alt_i = '0;
    logic signed [31:0] phs_ref_i = '0;
    logic signed [31:0] phs_alt_i = '0;
    logic        done_o;
    logic        err_o;
    logic signed [31:0] sin_o;
    logic signed [31:0] cos_o;
    logic [32:0] mag_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    phase_vec_norm u0 (
        .clk(clk), .rst(rst), .start(start),
        .mag_ref_i(mag_ref_i), .mag_alt_i(mag_alt_i),
        .phs_ref_i(phs_ref_i), .phs_alt_i(phs_alt_i),
        .done_o(done_o), .err_o(err_o),
        .sin_o(sin_o), .cos_o(cos_o), .mag_o(mag_o)
    );

    task automatic check(input string tag, input bit ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_scale(input int a, input int b);
        int d;
        int p;
        d = a - b;
        p = d * 256;
        return p / 32;
    endfunction

    function automatic longint ref_abs(input int v);
        return (v < 0) ? -longint'(v) : longint'(v);
    endfunction

    function automatic longint ref_mag(input int s, input int c);
        longint as_v = ref_abs(s);
        longint ac_v = ref_abs(c);
        longint hi = (as_v > ac_v) ? as_v : ac_v;
        longint lo = (as_v > ac_v) ? ac_v : as_v;
        return hi - hi / 32 + lo / 8 + lo / 4;
    endfunction

    function automatic int ref_norm(input int comp, input longint mag);
        longint q = (ref_abs(comp) * 32768) / mag;
        return (comp < 0) ? -int'(q) : int'(q);
    endfunction

    // issue a request, optionally fire a stray start mid-flight, then check everything
    task automatic run_case(input string name, input int m0, input int m1,
                            input int p0, input int p1, input bit stray);
        int s_exp = ref_scale(m0, m1);
        int c_exp = ref_scale(p1, p0);
        longint mg = ref_mag(s_exp, c_exp);
        bit e_exp = (mg == 0);
        int sin_exp = e_exp ? 0 : ref_norm(s_exp, mg);
        int cos_exp = e_exp ? 0 : ref_norm(c_exp, mg);
        int edges = 0;
        int lat_exp = e_exp ? LAT_ERR : LAT_OK;
        @(negedge clk);
        mag_ref_i = m0; mag_alt_i = m1; phs_ref_i = p0; phs_alt_i = p1;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done_o && edges < 200) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (stray && edges == 10) begin
                // R8: a different request while busy must be dropped
                mag_ref_i = 77777; mag_alt_i = -5; phs_ref_i = 9; phs_alt_i = -40000;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        $display("case %s", name);
        check({"R7 done seen ", name}, done_o, done_o, 1);
        check({"R10 latency ", name}, edges == lat_exp, edges, lat_exp);
        check({"R6 err ", name}, err_o == e_exp, err_o, e_exp);
        check({"R3 mag ", name}, longint'(mag_o) == (e_exp ? 0 : mg), mag_o, mg);
        check({"R1 R5 sin ", name}, sin_o == sin_exp, sin_o, sin_exp);
        check({"R2 R5 cos ", name}, cos_o == cos_exp, cos_o, cos_exp);
        @(negedge clk);
        check({"R7 pulse ends ", name}, !done_o, done_o, 0);
        check({"R7 hold sin ", name}, sin_o == sin_exp, sin_o, sin_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 done", done_o == 0, done_o, 0);
        check("R9 err", err_o == 0, err_o, 0);
        check("R9 sin", sin_o == 0, sin_o, 0);
        check("R9 cos", cos_o == 0, cos_o, 0);
        check("R9 mag", mag_o == 0, mag_o, 0);

        run_case("basic", 1000, 600, 200, 500, 1'b0);
        run_case("neg_sin", -900, 300, 50, 7000, 1'b0);
        run_case("neg_both", 12, 4012, 900, -2600, 1'b0);
        run_case("equal_abs", 100, 0, 100, 0, 1'b0);
        run_case("sin_zero", 555, 555, -3, 123456, 1'b0);
        // R4 R6 zero vector takes the short error path
        run_case("zero_err", 42, 42, -17, -17, 1'b0);
        // R7 success after error clears the flag
        run_case("after_err", 3, 1, 1, 2, 1'b0);
        // R1 wrap on the scale multiply gives a negative sine
        run_case("wrap", 32'h0040_0000, -32'sh0040_0000, 0, 3, 1'b0);
        run_case("busy_start", 250000, -10, -70000, 3000, 1'b1);
        run_case("tiny", 0, 1, 0, 0, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule